// File: doc/BRIEF.md
# Dual-Source Serial Delay Shift Register

This block is a fixed-length serial-in, serial-out shift register of 64 stages. A select input decides which of two serial data inputs feeds the first stage on each rising clock edge. The bit at the far end of the chain comes out three ways. One output gives the bit as it is. One gives its inverse. A third output is re-timed on the falling clock edge, so it lags the plain output by half a clock period. A buffered copy of the clock is also driven out, so a following stage can be cascaded on the same timing.

The block is used as a long digital delay line or as a recirculating store. Data is set up while the clock is low and is taken in when the clock rises. There is no reset. For simulation every stage starts at 0, and a user flushes the chain with known data before relying on the output.

Top module: `dual_src_shreg`

## Requirements
- R1: A bit sampled on a rising edge appears on `q_true` right after the 64th rising edge counting that sampling edge, and not before it.
- R2: While `sel_src` is 0 at a rising edge, `din_a` is taken into the first stage and `din_b` has no effect on any output.
- R3: While `sel_src` is 1 at a rising edge, `din_b` is taken into the first stage and `din_a` has no effect on any output.
- R4: `q_inv` is always the inverse of `q_true`.
- R5: During every clock-low phase, `q_late` equals `q_true`.
- R6: During the clock-high phase right after a rising edge, `q_late` still holds the value `q_true` had before that edge.
- R7: `clk_buf` follows the level of `clk_in` in both phases.
- R8: All stages start at 0, so before the first rising edge `q_true`, `q_inv` and `q_late` read 0, 1 and 0.
- R9: A change of `sel_src` takes effect at the next rising edge, even when the select changes on every cycle.
- R10: After 32 pairs of the bits 1 then 0 have been shifted in from either source, the triple (`q_true`, `q_inv`, `q_late`) reads 1,0,1 in the low phase. After one more edge it reads 0,1,0, and after another it reads 1,0,1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Shift clock. Data is sampled on the rising edge. |
| sel_src | input | 1 | Source select: 0 takes `din_a`, 1 takes `din_b`. |
| din_a | input | 1 | First serial data input. |
| din_b | input | 1 | Second serial data input. |
| q_true | output | 1 | Last stage, true polarity. |
| q_inv | output | 1 | Last stage, inverted. |
| q_late | output | 1 | Last stage re-timed on the falling edge. |
| clk_buf | output | 1 | Buffered copy of `clk_in`. |

## Verification
Suppose a single stage holds a wrong bit, or the select picks the wrong source. The fault stays hidden until that bit has walked to the end of the chain. It then shows on `q_true`, `q_inv` and `q_late` at the same time, up to 63 edges later. For this reason the bench keeps its own 64-entry model of every accepted bit and compares all three outputs in every low phase. A fault in the falling-edge re-timing shows much sooner. It appears in the high phase just after the edge, where `q_late` must still carry the old value.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    localparam int unsigned DEFAULT_DEPTH = 64;

    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;

endpackage

// File: rtl/shreg_src_mux.sv
module shreg_src_mux
    import shreg_pkg::*;
(
    input  src_e sel_i,
    input  logic a_i,
    input  logic b_i,
    output logic bit_o
);

    always_comb begin
        unique case (sel_i)
            SRC_A:   bit_o = a_i;
            SRC_B:   bit_o = b_i;
            default: bit_o = a_i;
        endcase
    end

endmodule

// File: rtl/shreg_chain.sv
module shreg_chain #(
    parameter int unsigned DEPTH = shreg_pkg::DEFAULT_DEPTH
) (
    input  logic             clk_i,
    input  logic             bit_i,
    output logic [DEPTH-1:0] stages_o
);

    typedef struct packed {
        logic [DEPTH-1:0] stages;
    } chain_t;

    chain_t chain_d;
    chain_t chain_q = '0;   // simulation start state: all stages cleared

    generate
        if (DEPTH == 1) begin : g_single
            always_comb begin
                chain_d        = chain_q;
                chain_d.stages = bit_i;
            end
        end else begin : g_multi
            always_comb begin
                chain_d        = chain_q;
                chain_d.stages = {chain_q.stages[DEPTH-2:0], bit_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        chain_q <= chain_d;
    end

    assign stages_o = chain_q.stages;

endmodule

// File: rtl/shreg_tail.sv
module shreg_tail (
    input  logic clk_i,
    input  logic tail_i,
    output logic q_true_o,
    output logic q_inv_o,
    output logic q_late_o
);

    typedef struct packed {
        logic late;
    } tail_t;

    tail_t tail_d;
    tail_t tail_q = '0;

    always_comb begin
        tail_d      = tail_q;
        tail_d.late = tail_i;
    end

    // re-time on the falling edge: half a period behind the chain
    always_ff @(negedge clk_i) begin
        tail_q <= tail_d;
    end

    assign q_true_o = tail_i;
    assign q_inv_o  = ~tail_i;
    assign q_late_o = tail_q.late;

endmodule

// File: rtl/dual_src_shreg.sv
module dual_src_shreg
    import shreg_pkg::*;
#(
    parameter int unsigned DEPTH = DEFAULT_DEPTH
) (
    input  logic clk_in,
    input  logic sel_src,
    input  logic din_a,
    input  logic din_b,
    output logic q_true,
    output logic q_inv,
    output logic q_late,
    output logic clk_buf
);

    localparam int unsigned LAST = DEPTH - 1;

    src_e             sel_e;
    logic             head_bit;
    logic [DEPTH-1:0] stages;

    assign sel_e = src_e'(sel_src);

    shreg_src_mux i_mux (
        .sel_i (sel_e),
        .a_i   (din_a),
        .b_i   (din_b),
        .bit_o (head_bit)
    );

    shreg_chain #(.DEPTH(DEPTH)) i_chain (
        .clk_i    (clk_in),
        .bit_i    (head_bit),
        .stages_o (stages)
    );

    shreg_tail i_tail (
        .clk_i    (clk_in),
        .tail_i   (stages[LAST]),
        .q_true_o (q_true),
        .q_inv_o  (q_inv),
        .q_late_o (q_late)
    );

    assign clk_buf = clk_in;

endmodule

// File: rtl/dual_src_shreg_chk.sv
module dual_src_shreg_chk #(
    parameter int unsigned DEPTH = 64
) (
    input logic             clk_in,
    input logic             sel_src,
    input logic             din_a,
    input logic             din_b,
    input logic             q_true,
    input logic             q_late,
    input logic [DEPTH-1:0] stages
);

    logic [1:0] pos_seen = 2'd0;
    logic [1:0] neg_seen = 2'd0;

    always_ff @(posedge clk_in) if (pos_seen != 2'd3) pos_seen <= pos_seen + 2'd1;
    always_ff @(negedge clk_in) if (neg_seen != 2'd3) neg_seen <= neg_seen + 2'd1;

    // R2: select 0 loads din_a into the first stage
    p_src_a_r2: assert property (@(posedge clk_in) disable iff (pos_seen == 2'd0)
        (sel_src == 1'b0) |=> (stages[0] == $past(din_a)));

    // R3: select 1 loads din_b into the first stage
    p_src_b_r3: assert property (@(posedge clk_in) disable iff (pos_seen == 2'd0)
        (sel_src == 1'b1) |=> (stages[0] == $past(din_b)));

    // R1: the output is one edge behind the stage before it
    p_tail_step_r1: assert property (@(posedge clk_in) disable iff (pos_seen == 2'd0)
        1'b1 |=> (q_true == $past(stages[DEPTH-2])));

    // R5: seen at a rising edge, the low phase just ended with q_late equal to q_true
    p_late_match_r5: assert property (@(posedge clk_in) disable iff (neg_seen == 2'd0)
        q_late == q_true);

    // R6: q_late only moves at falling edges
    p_late_hold_r6: assert property (@(negedge clk_in) disable iff (neg_seen == 2'd0)
        q_late == $past(q_true));

endmodule

bind dual_src_shreg dual_src_shreg_chk #(.DEPTH(DEPTH)) i_chk (
    .clk_in  (clk_in),
    .sel_src (sel_src),
    .din_a   (din_a),
    .din_b   (din_b),
    .q_true  (q_true),
    .q_late  (q_late),
    .stages  (stages)
);

// File: tb/test_dual_src_shreg.sv
module test_dual_src_shreg;

    localparam int DEPTH = 64;

    logic clk = 1'b0;
    logic sel_src = 1'b0;
    logic din_a = 1'b0;
    logic din_b = 1'b0;
    logic q_true, q_inv, q_late, clk_buf;

    int n_cmp = 0;
    int n_bad = 0;
    logic [DEPTH-1:0] mdl = '0;
    logic [15:0] lfsr = 16'hACE1;
    logic done = 1'b0;

    always #5 clk = ~clk;

    dual_src_shreg #(.DEPTH(DEPTH)) i_dual_src_shreg (
        .clk_in  (clk),
        .sel_src (sel_src),
        .din_a   (din_a),
        .din_b   (din_b),
        .q_true  (q_true),
        .q_inv   (q_inv),
        .q_late  (q_late),
        .clk_buf (clk_buf)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // one clock: drive in the low phase, check just after the rise and in the next low phase
    task automatic step(input logic s, input logic a, input logic b, input string tag);
        logic old_true;
        old_true = mdl[DEPTH-1];
        #1;
        sel_src = s; din_a = a; din_b = b;
        @(posedge clk);
        #1;
        chk("R6 late hold", q_late, old_true);
        chk("R7 clk high", clk_buf, 1'b1);
        mdl = {mdl[DEPTH-2:0], (s ? b : a)};
        @(negedge clk);
        #2;
        chk(tag, q_true, mdl[DEPTH-1]);
        chk("R4 inverse", q_inv, ~mdl[DEPTH-1]);
        chk("R5 late low", q_late, mdl[DEPTH-1]);
        chk("R7 clk low", clk_buf, 1'b0);
    endtask

    task automatic triple(input string tag, input logic t, input logic i, input logic l);
        chk({tag, " true"}, q_true, t);
        chk({tag, " inv"}, q_inv, i);
        chk({tag, " late"}, q_late, l);
    endtask

    initial begin
        #1;
        // R8: start state before any edge
        triple("R8", 1'b0, 1'b1, 1'b0);
        chk("R7 clk low", clk_buf, 1'b0);

        // R1: ones from din_a; output stays 0 for 63 edges, then 1
        for (int k = 1; k <= DEPTH; k++) begin
            step(1'b0, 1'b1, 1'b0, "R1 latency");
            if (k == DEPTH - 1) chk("R1 not early", q_true, 1'b0);
            if (k == DEPTH)     chk("R1 arrival", q_true, 1'b1);
        end

        // R10 and R2: pairs 1,0 on din_a, din_b toggling as noise
        for (int k = 0; k < 32; k++) begin
            step(1'b0, 1'b1, 1'b0, "R2 source a");
            step(1'b0, 1'b0, 1'b1, "R2 source a");
        end
        triple("R10 a first", 1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1, "R2 source a");
        triple("R10 a second", 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1, "R2 source a");
        triple("R10 a third", 1'b1, 1'b0, 1'b1);

        // R10 and R3: pairs 1,0 on din_b, din_a opposite as noise
        for (int k = 0; k < 32; k++) begin
            step(1'b1, 1'b0, 1'b1, "R3 source b");
            step(1'b1, 1'b1, 1'b0, "R3 source b");
        end
        triple("R10 b first", 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0, "R3 source b");
        triple("R10 b second", 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, "R3 source b");
        triple("R10 b third", 1'b1, 1'b0, 1'b1);

        // R9: select flips every edge, sources held at opposite constants
        for (int k = 0; k < 3 * DEPTH; k++)
            step(k[0], 1'b1, 1'b0, "R9 select switch");

        // sweep with pseudo-random select and data
        for (int k = 0; k < 6 * DEPTH; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[3], lfsr[7], "R1 sweep");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog at %0t: actual hung expected finished", $time);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule